// File: doc/BRIEF.md
# Two-Context Thread Switch Controller

This block chooses which of two hardware thread contexts feeds a shared in-order pipeline. One context, the foreground thread, issues instructions. The other context waits in the background. Each context is presented to software as its own logical processor number. The pipeline reports cache misses for each thread, and each miss carries a latency class: long (a second-level miss) or short (a first-level miss). It also reports when each outstanding miss completes. From these events the controller keeps a ready flag for each thread and decides when to hand the pipeline to the other context.

A switch is announced with a one-cycle pulse, so that the pipeline can flush the instructions of the outgoing thread. The active thread changes in the cycle after the pulse.

The two latency classes are treated differently:
- A miss of either class on the foreground thread causes a switch at once if the background thread is ready.
- A long stall is remembered. When the background thread later becomes ready, the controller switches to it.
- A short stall is not remembered. The foreground thread keeps ownership and waits for its own miss to complete.
- When no thread can issue, the issue enable output is held low.

Top module: `tsw_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the outputs take their initial values. The active thread is 0. Both ready bits are 1. The switch pulse is low and the issue enable is high.
- R2: The ready bit of a thread goes to 0 in the cycle after a miss on that thread is sampled. It returns to 1 in the cycle after a completion for that thread is sampled. If a miss and a completion arrive for the same thread in the same cycle, the miss wins and the ready bit goes to 0.
- R3: A long miss (class input 1) on the foreground thread while the background thread is ready gives a switch pulse in the next cycle.
- R4: A short miss (class input 0) on the foreground thread while the background thread is ready also gives a switch pulse in the next cycle.
- R5: A short miss on the foreground thread while the background thread is stalled gives no switch. The foreground thread stays active. It keeps the pipeline even if the background thread becomes ready before the short miss completes.
- R6: A long miss on the foreground thread while the background thread is stalled is recorded. The switch pulse appears in the cycle after the completion for the background thread is sampled.
- R7: The switch pulse lasts exactly one cycle, and the issue enable is low during it. The active thread toggles in the cycle after the pulse and changes at no other time.
- R8: When the foreground thread is stalled, the issue enable is low. This includes the case where both threads are stalled. No switch pulse is raised while neither thread is ready.
- R9: When a switch happens, the outgoing thread keeps its pending miss, and its ready bit stays 0. When its completion arrives while the new foreground thread is held by a long miss, the controller switches back to it.
- R10: The active logical processor output equals the parameter LP_BASE plus the active thread number.
- R11: No new switch decision is taken in the pulse cycle. A stall that arises in the pulse cycle is judged in the first cycle after the toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| miss_vld | input | 2 | Miss event, one bit per thread |
| miss_long | input | 2 | Latency class of the miss, one bit per thread (1 = long, 0 = short) |
| miss_done | input | 2 | Outstanding miss completed, one bit per thread |
| active_tid | output | 1 | Current foreground thread |
| switch_pulse | output | 1 | One-cycle flush and switch indication |
| issue_en | output | 1 | Foreground thread may issue |
| thr_ready | output | 2 | Ready bit of each thread |
| active_lp | output | LP_W | Logical processor number of the foreground thread |

## Verification
The switch rule is tried with several kinds of foreground miss:
- long and short misses against a ready background, which tells the immediate switch apart from no switch;
- long and short misses against a stalled background, where only the long stall leads to a switch once the background's completion arrives;
- a miss and a completion in the same cycle;
- a stall raised during the pulse cycle, which checks that no decision is taken there;
- a switch back to a thread that still held its pending miss.

A long random run of misses and completions is then compared, cycle by cycle, against a reference model of the rules.

// File: rtl/tsw_pkg.sv
// Package: types shared by the thread switch controller.
// Assumes exactly two thread contexts.
package tsw_pkg;
    localparam int NTHR = 2;

    // Per-thread status: issue readiness and whether the current stall is long.
    typedef struct packed {
        logic rdy;
        logic lng;
    } tstat_t;
endpackage

// File: rtl/tsw_trk.sv
// Module: per-thread stall tracker. It holds the ready bit and the latency class of
// the outstanding miss. It also exposes the next-state value so that the policy can
// act on events from the same cycle. Assumes a miss takes precedence over a
// completion that arrives in the same cycle.
module tsw_trk
    import tsw_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   miss_i,
    input  logic   long_i,
    input  logic   done_i,
    output tstat_t nx_o,
    output tstat_t cur_o
);
    tstat_t st_q;
    tstat_t st_d;

    // Next status: a miss stalls the thread and records its class; a completion releases it.
    always_comb begin
        st_d = st_q;
        if (miss_i) begin
            st_d.rdy = 1'b0;
            st_d.lng = long_i;
        end else if (done_i) begin
            st_d.rdy = 1'b1;
            st_d.lng = 1'b0;
        end
    end

    // Status register, reset to ready with no long stall.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{rdy: 1'b1, lng: 1'b0};
        else        st_q <= st_d;
    end

    assign nx_o  = st_d;
    assign cur_o = st_q;

    a_r2_miss_clears: assert property (@(posedge clk) disable iff (!rst_n)
        miss_i |=> !cur_o.rdy);
    a_r2_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !miss_i) |=> cur_o.rdy);
endmodule

// File: rtl/tsw_pol.sv
// Module: switch policy. It is purely combinational. From the next-state thread
// status and this cycle's foreground miss, it decides whether a switch is requested.
// Assumes hold_i is high during the pulse cycle, which blocks any decision.
module tsw_pol
    import tsw_pkg::*;
(
    input  logic                fg_i,
    input  logic                hold_i,
    input  logic [NTHR-1:0]     miss_i,
    input  tstat_t [NTHR-1:0]   nx_i,
    output logic                sw_req_o
);
    logic bg;
    logic fg_stall;
    logic bg_ok;
    logic fg_event;
    logic fg_long;

    // Request rule: the foreground is stalled, the background is ready, and either a
    // fresh miss happened this cycle or a long stall is on record.
    always_comb begin
        bg       = ~fg_i;
        fg_stall = ~nx_i[fg_i].rdy;
        bg_ok    = nx_i[bg].rdy;
        fg_event = miss_i[fg_i];
        fg_long  = nx_i[fg_i].lng;
        sw_req_o = ~hold_i & fg_stall & bg_ok & (fg_event | fg_long);
    end
endmodule

// File: rtl/tsw_seq.sv
// Module: switch sequencer. It registers a switch request into a one-cycle pulse and
// toggles the foreground thread on the edge that ends the pulse.
// Assumes the policy holds the request low while the pulse is high.
module tsw_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_req_i,
    output logic fg_o,
    output logic sw_o
);
    logic fg_q;
    logic sw_q;

    // Pulse and foreground registers; the foreground flips only when the pulse retires.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fg_q <= 1'b0;
            sw_q <= 1'b0;
        end else begin
            sw_q <= sw_req_i;
            if (sw_q) fg_q <= ~fg_q;
        end
    end

    assign fg_o = fg_q;
    assign sw_o = sw_q;

    a_r7_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        sw_q |=> !sw_q);
    a_r7_tid_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        sw_q |=> (fg_q != $past(fg_q)));
    a_r11_tid_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_q |=> (fg_q == $past(fg_q)));
endmodule

// File: rtl/tsw_ctrl.sv
// Module: top of the two-context thread switch controller. It instantiates one stall
// tracker per thread, the switch policy and the sequencer, and it forms the issue
// enable and the logical processor number. Assumes misses arrive only for outstanding
// work and that LP_BASE + 1 fits in LP_W bits.
module tsw_ctrl
    import tsw_pkg::*;
#(
    parameter int LP_BASE = 6,
    parameter int LP_W    = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      miss_vld,
    input  logic [1:0]      miss_long,
    input  logic [1:0]      miss_done,
    output logic            active_tid,
    output logic            switch_pulse,
    output logic            issue_en,
    output logic [1:0]      thr_ready,
    output logic [LP_W-1:0] active_lp
);
    localparam logic [LP_W-1:0] LP_BASE_V = LP_W'(LP_BASE);

    tstat_t [NTHR-1:0] st_nx;
    tstat_t [NTHR-1:0] st_cur;
    logic              sw_req;
    logic              fg;
    logic              sw;

    for (genvar t = 0; t < NTHR; t++) begin : g_thr
        tsw_trk u_trk (
            .clk    (clk),
            .rst_n  (rst_n),
            .miss_i (miss_vld[t]),
            .long_i (miss_long[t]),
            .done_i (miss_done[t]),
            .nx_o   (st_nx[t]),
            .cur_o  (st_cur[t])
        );
        assign thr_ready[t] = st_cur[t].rdy;
    end

    tsw_pol u_pol (
        .fg_i     (fg),
        .hold_i   (sw),
        .miss_i   (miss_vld),
        .nx_i     (st_nx),
        .sw_req_o (sw_req)
    );

    tsw_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .sw_req_i (sw_req),
        .fg_o     (fg),
        .sw_o     (sw)
    );

    // Output forming: issue only outside the flush cycle and only while the foreground is ready.
    always_comb begin
        active_tid   = fg;
        switch_pulse = sw;
        issue_en     = st_cur[fg].rdy & ~sw;
        active_lp    = LP_BASE_V + {{(LP_W-1){1'b0}}, fg};
    end

    a_r5_target_ready: assert property (@(posedge clk) disable iff (!rst_n)
        switch_pulse |-> thr_ready[~active_tid]);
    a_r5_outgoing_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        switch_pulse |-> !thr_ready[active_tid]);
    a_r8_no_issue_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_ready == 2'b00) |-> (!issue_en && !switch_pulse));
endmodule

// File: tb/sim_tsw_ctrl.sv
`timescale 1ns/1ps
module sim_tsw_ctrl;
    localparam int LPB = 6;
    localparam int LPW = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [1:0]     miss_vld = '0;
    logic [1:0]     miss_long = '0;
    logic [1:0]     miss_done = '0;
    logic           active_tid;
    logic           switch_pulse;
    logic           issue_en;
    logic [1:0]     thr_ready;
    logic [LPW-1:0] active_lp;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // Reference model state.
    logic       m_fg;
    logic       m_sw;
    logic [1:0] m_rdy;
    logic [1:0] m_lng;

    always #2 clk = ~clk;

    tsw_ctrl #(.LP_BASE(LPB), .LP_W(LPW)) u0 (
        .clk(clk), .rst_n(rst_n), .miss_vld(miss_vld), .miss_long(miss_long),
        .miss_done(miss_done), .active_tid(active_tid), .switch_pulse(switch_pulse),
        .issue_en(issue_en), .thr_ready(thr_ready), .active_lp(active_lp)
    );

    task automatic chk(input string req, input string what, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
        end
    endtask

    // Compare all outputs with the reference model.
    task automatic cmp_model(input string req);
        chk(req, "active_tid", 8'(active_tid), 8'(m_fg));
        chk(req, "switch_pulse", 8'(switch_pulse), 8'(m_sw));
        chk(req, "thr_ready", 8'(thr_ready), 8'(m_rdy));
        chk(req, "issue_en", 8'(issue_en), 8'(m_rdy[m_fg] & ~m_sw));
        chk(req, "active_lp", 8'(active_lp), 8'(LPB + int'(m_fg)));
    endtask

    task automatic do_reset();
        rst_n = 1'b0; miss_vld = '0; miss_long = '0; miss_done = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_fg = 1'b0; m_sw = 1'b0; m_rdy = 2'b11; m_lng = 2'b00;
    endtask

    // Apply one cycle of inputs at a falling edge, advance the model, and compare at the next falling edge.
    task automatic step(input logic [1:0] m, input logic [1:0] l, input logic [1:0] r);
        logic [1:0] rn;
        logic [1:0] ln;
        miss_vld = m; miss_long = l; miss_done = r;
        for (int t = 0; t < 2; t++) begin
            rn[t] = m[t] ? 1'b0 : (r[t] ? 1'b1 : m_rdy[t]);
            ln[t] = m[t] ? l[t] : (r[t] ? 1'b0 : m_lng[t]);
        end
        if (m_sw) begin
            m_fg = ~m_fg;
            m_sw = 1'b0;
        end else begin
            m_sw = ~rn[m_fg] & rn[~m_fg] & (m[m_fg] | ln[m_fg]);
        end
        m_rdy = rn; m_lng = ln;
        @(negedge clk);
        miss_vld = '0; miss_long = '0; miss_done = '0;
        cmp_model("R3 R4 R5 R6 model");
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1", "active_tid", 8'(active_tid), 8'd0);
        chk("R1", "thr_ready", 8'(thr_ready), 8'h3);
        chk("R1", "switch_pulse", 8'(switch_pulse), 8'd0);
        chk("R1", "issue_en", 8'(issue_en), 8'd1);
        chk("R10", "active_lp", 8'(active_lp), 8'(LPB));
    endtask

    task automatic t_long_switch();
        do_reset();
        step(2'b01, 2'b01, 2'b00);
        chk("R3", "switch_pulse", 8'(switch_pulse), 8'd1);
        chk("R7", "issue_en in pulse", 8'(issue_en), 8'd0);
        chk("R7", "active_tid in pulse", 8'(active_tid), 8'd0);
        step(2'b00, 2'b00, 2'b00);
        chk("R7", "switch_pulse width", 8'(switch_pulse), 8'd0);
        chk("R7", "active_tid after", 8'(active_tid), 8'd1);
        chk("R10", "active_lp", 8'(active_lp), 8'(LPB + 1));
    endtask

    task automatic t_short_switch();
        do_reset();
        step(2'b01, 2'b00, 2'b00);
        chk("R4", "switch_pulse", 8'(switch_pulse), 8'd1);
        step(2'b00, 2'b00, 2'b00);
        chk("R4", "active_tid", 8'(active_tid), 8'd1);
        chk("R4", "issue_en", 8'(issue_en), 8'd1);
    endtask

    task automatic t_short_blocked();
        do_reset();
        step(2'b10, 2'b00, 2'b00);
        chk("R2", "thr_ready bg miss", 8'(thr_ready), 8'h1);
        step(2'b01, 2'b00, 2'b00);
        chk("R5", "switch_pulse", 8'(switch_pulse), 8'd0);
        chk("R8", "issue_en both stalled", 8'(issue_en), 8'd0);
        step(2'b00, 2'b00, 2'b10);
        chk("R5", "no switch on bg ready", 8'(switch_pulse), 8'd0);
        step(2'b00, 2'b00, 2'b00);
        chk("R5", "active_tid", 8'(active_tid), 8'd0);
        step(2'b00, 2'b00, 2'b01);
        chk("R2", "thr_ready restored", 8'(thr_ready), 8'h3);
        chk("R5", "issue_en resumes", 8'(issue_en), 8'd1);
    endtask

    task automatic t_long_wait();
        do_reset();
        step(2'b10, 2'b00, 2'b00);
        step(2'b01, 2'b01, 2'b00);
        chk("R6", "no pulse while bg stalled", 8'(switch_pulse), 8'd0);
        step(2'b00, 2'b00, 2'b00);
        step(2'b00, 2'b00, 2'b00);
        chk("R8", "idle hold", 8'(issue_en), 8'd0);
        step(2'b00, 2'b00, 2'b10);
        chk("R6", "pulse after bg done", 8'(switch_pulse), 8'd1);
        step(2'b00, 2'b00, 2'b00);
        chk("R6", "active_tid", 8'(active_tid), 8'd1);
    endtask

    task automatic t_keep_pending();
        do_reset();
        step(2'b01, 2'b01, 2'b00);
        step(2'b00, 2'b00, 2'b00);
        chk("R9", "old fg still stalled", 8'(thr_ready), 8'h2);
        step(2'b10, 2'b10, 2'b00);
        chk("R9", "no switch to stalled", 8'(switch_pulse), 8'd0);
        step(2'b00, 2'b00, 2'b01);
        chk("R9", "switch back pulse", 8'(switch_pulse), 8'd1);
        step(2'b00, 2'b00, 2'b00);
        chk("R9", "active_tid back", 8'(active_tid), 8'd0);
    endtask

    task automatic t_suppress();
        do_reset();
        step(2'b01, 2'b01, 2'b00);
        step(2'b10, 2'b10, 2'b01);
        chk("R11", "no pulse after pulse", 8'(switch_pulse), 8'd0);
        chk("R11", "active_tid toggled", 8'(active_tid), 8'd1);
        step(2'b00, 2'b00, 2'b00);
        chk("R11", "judged after toggle", 8'(switch_pulse), 8'd1);
        step(2'b00, 2'b00, 2'b00);
        chk("R11", "active_tid", 8'(active_tid), 8'd0);
    endtask

    task automatic t_same_cycle();
        do_reset();
        step(2'b10, 2'b00, 2'b10);
        chk("R2", "miss wins", 8'(thr_ready), 8'h1);
        step(2'b00, 2'b00, 2'b10);
        chk("R2", "done sets", 8'(thr_ready), 8'h3);
    endtask

    task automatic t_random();
        do_reset();
        for (int i = 0; i < 4000; i++) begin
            logic [1:0] m;
            logic [1:0] l;
            logic [1:0] r;
            for (int t = 0; t < 2; t++) begin
                m[t] = ($urandom % 7) == 0;
                l[t] = $urandom % 2;
                r[t] = ($urandom % 4) == 0;
            end
            step(m, l, r);
        end
    endtask

    initial begin
        t_reset();
        t_long_switch();
        t_short_switch();
        t_short_blocked();
        t_long_wait();
        t_keep_pending();
        t_suppress();
        t_same_cycle();
        t_random();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL R1 watchdog: actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule